// File: doc/BRIEF.md
# Run-Length Codec for a Bidirectional Parallel Byte Channel

This block sits between a parallel port's byte channel and its FIFOs, with one path for each direction. On the receive path, every item is a byte plus a one-bit tag that marks it as either a command or data. A command byte with its top bit clear is a run-length count. The expander takes that count in and does not forward it. It then writes the next data byte count+1 times, so a run can hold from 1 to 128 bytes. Command bytes with the top bit set are channel addresses, and they pass through unchanged.

The transmit path is an optional compressor, chosen with a parameter. It merges consecutive identical data bytes into one count byte followed by the byte itself. A lone byte goes out with no count. A pending run goes out when:
- a different byte arrives,
- a command arrives,
- the run reaches 128, or
- the producer marks an input item as the last one.

Both paths use valid/ready streams. The paths have no handshake on the port side.

Top module: `rle_codec`

## Requirements
- R1: On the receive path, a data item (tag 0) that has no count before it is forwarded exactly once, with its tag and byte unchanged, and item order is kept.
- R2: A receive command item (tag 1) whose data bit 7 is 0 is never forwarded. Its bits 6:0 hold a value n, and the next data item is forwarded n+1 times. This covers n = 0 (one copy) and n = 127 (128 copies).
- R3: A receive command item whose data bit 7 is 1 is forwarded once, with tag 1 and its byte unchanged.
- R4: While a run is being expanded, `rx_in_ready` stays 0. Output valid stays 1, with the tag and byte stable, until every copy has been accepted.
- R5: If a count item is followed by another command item, the earlier count is dropped. A following address makes the next data byte appear once. A following count replaces the earlier one.
- R6: On the transmit path, a run of n identical data bytes with 2 ≤ n ≤ 128 goes out as a command item with byte n-1 (bit 7 = 0), followed by the byte as data (tag 0).
- R7: A transmit run of length 1 goes out as the data byte alone, with no count item.
- R8: A transmit run longer than 128 bytes is split, so that every emitted count is at most 127.
- R9: A pending transmit run is flushed when a different byte arrives, or when an input item carries `tx_in_last`. A transmit command item first flushes any pending run and is then forwarded unchanged.
- R10: While reset is active, both output valids are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_in_valid | input | 1 | Receive input item valid |
| rx_in_ready | output | 1 | Receive input item accepted |
| rx_in_cmd | input | 1 | Receive input tag (1 = command) |
| rx_in_data | input | 8 | Receive input byte |
| rx_out_valid | output | 1 | Expanded item valid |
| rx_out_ready | input | 1 | Downstream accepts expanded item |
| rx_out_cmd | output | 1 | Expanded item tag |
| rx_out_data | output | 8 | Expanded item byte |
| tx_in_valid | input | 1 | Transmit input item valid |
| tx_in_ready | output | 1 | Transmit input item accepted |
| tx_in_cmd | input | 1 | Transmit input tag |
| tx_in_data | input | 8 | Transmit input byte |
| tx_in_last | input | 1 | Marks the final item of the transmit stream |
| tx_out_valid | output | 1 | Compressed item valid |
| tx_out_ready | input | 1 | Downstream accepts compressed item |
| tx_out_cmd | output | 1 | Compressed item tag |
| tx_out_data | output | 8 | Compressed item byte |

## Verification
The stability assertions assume that the downstream side behaves as a valid/ready sink, and that the upstream side holds an item steady until it is taken. The stimulus keeps to this by changing inputs only on the falling clock edge, and by holding an item until ready is seen high. The compressor's in_ready looks at the offered byte, because it must refuse a byte that would end the current run. The bench therefore offers each item and waits, rather than sampling ready beforehand. Downstream ready is toggled pseudo-randomly and is also held low for long stretches, so that expansion under backpressure gets exercised.

// File: rtl/rle_pkg.sv
package rle_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = BYTE_W - 1;

    typedef struct packed {
        logic              cmd;
        logic [BYTE_W-1:0] data;
    } item_t;

    typedef enum logic [1:0] {
        ENC_COLLECT = 2'd0,
        ENC_FLUSH   = 2'd1,
        ENC_TAIL    = 2'd2
    } enc_st_e;
endpackage

// File: rtl/rle_expand.sv
module rle_expand
    import rle_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  in_valid,
    output logic  in_ready,
    input  item_t in_item,
    output logic  out_valid,
    input  logic  out_ready,
    output item_t out_item
);
    typedef struct packed {
        logic             ovld;
        item_t            oitem;
        logic [CNT_W-1:0] rem;
        logic             pend;
        logic [CNT_W-1:0] pcnt;
    } exp_state_t;

    exp_state_t st_d, st_q;
    logic       last_rep;
    logic       is_count;

    always_comb begin
        st_d     = st_q;
        last_rep = (st_q.rem == '0);
        is_count = in_item.cmd && !in_item.data[BYTE_W-1];
        in_ready = !st_q.ovld || (out_ready && last_rep);

        if (st_q.ovld && out_ready) begin
            if (!last_rep) begin
                st_d.rem = st_q.rem - 1'b1;
            end else begin
                st_d.ovld = 1'b0;
            end
        end

        if (in_valid && in_ready) begin
            if (is_count) begin
                st_d.pend = 1'b1;
                st_d.pcnt = in_item.data[CNT_W-1:0];
            end else begin
                st_d.ovld  = 1'b1;
                st_d.oitem = in_item;
                st_d.rem   = (!in_item.cmd && st_q.pend) ? st_q.pcnt : '0;
                st_d.pend  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.ovld;
    assign out_item  = st_q.oitem;

    // R4: an offered item holds until taken
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_item));

    // R2: count bytes never reach the output
    a_r2_no_count_out: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_item.cmd |-> out_item.data[BYTE_W-1]);

    // R2: a data byte after a count appears at the output next cycle
    a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && !in_item.cmd && st_q.pend
        |=> out_valid && !out_item.cmd && out_item.data == $past(in_item.data));

    // R4: the input is refused while copies remain and the sink stalls
    a_r4_stall: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |-> !in_ready);
endmodule

// File: rtl/rle_compress.sv
module rle_compress
    import rle_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  in_valid,
    output logic  in_ready,
    input  item_t in_item,
    input  logic  in_last,
    output logic  out_valid,
    input  logic  out_ready,
    output item_t out_item
);
    typedef struct packed {
        enc_st_e           st;
        logic              ovld;
        item_t             oitem;
        logic              rvld;
        logic [BYTE_W-1:0] rbyte;
        logic [CNT_W-1:0]  rlen;
    } enc_state_t;

    enc_state_t       st_d, st_q;
    logic             free;
    logic             clash;
    logic [CNT_W-1:0] nlen;

    always_comb begin
        st_d     = st_q;
        free     = !st_q.ovld || out_ready;
        clash    = st_q.rvld && (in_item.cmd || in_item.data != st_q.rbyte);
        nlen     = st_q.rvld ? st_q.rlen + 1'b1 : '0;
        in_ready = (st_q.st == ENC_COLLECT) && free && !(in_valid && clash);

        if (st_q.ovld && out_ready) begin
            st_d.ovld = 1'b0;
        end

        unique case (st_q.st)
            ENC_COLLECT: begin
                if (in_valid && clash) begin
                    st_d.st = ENC_FLUSH;
                end else if (in_valid && in_ready) begin
                    if (in_item.cmd) begin
                        st_d.ovld  = 1'b1;
                        st_d.oitem = in_item;
                    end else begin
                        st_d.rvld  = 1'b1;
                        st_d.rbyte = in_item.data;
                        st_d.rlen  = nlen;
                        if (in_last || (&nlen)) begin
                            st_d.st = ENC_FLUSH;
                        end
                    end
                end
            end
            ENC_FLUSH: begin
                if (free) begin
                    st_d.ovld = 1'b1;
                    if (st_q.rlen != '0) begin
                        st_d.oitem = '{cmd: 1'b1, data: {1'b0, st_q.rlen}};
                        st_d.st    = ENC_TAIL;
                    end else begin
                        st_d.oitem = '{cmd: 1'b0, data: st_q.rbyte};
                        st_d.rvld  = 1'b0;
                        st_d.st    = ENC_COLLECT;
                    end
                end
            end
            ENC_TAIL: begin
                if (free) begin
                    st_d.ovld  = 1'b1;
                    st_d.oitem = '{cmd: 1'b0, data: st_q.rbyte};
                    st_d.rvld  = 1'b0;
                    st_d.st    = ENC_COLLECT;
                end
            end
            default: st_d.st = ENC_COLLECT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.ovld;
    assign out_item  = st_q.oitem;

    // R9: an offered item holds until taken
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_item));

    // R6: an accepted count item is followed at once by a data item
    a_r6_cnt_then_byte: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && out_item.cmd && !out_item.data[BYTE_W-1]
        |=> out_valid && !out_item.cmd);

    // R7: a count item always stands for a run of two or more
    a_r7_no_unit_count: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_item.cmd && !out_item.data[BYTE_W-1]
        |-> out_item.data[CNT_W-1:0] != '0);

    // R9: a byte that ends the current run is refused
    a_r9_refuse_clash: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && st_q.rvld && !in_item.cmd && in_item.data != st_q.rbyte
        |-> !in_ready);
endmodule

// File: rtl/rle_codec.sv
module rle_codec
    import rle_pkg::*;
#(
    parameter bit ENC_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_in_valid,
    output logic              rx_in_ready,
    input  logic              rx_in_cmd,
    input  logic [BYTE_W-1:0] rx_in_data,
    output logic              rx_out_valid,
    input  logic              rx_out_ready,
    output logic              rx_out_cmd,
    output logic [BYTE_W-1:0] rx_out_data,
    input  logic              tx_in_valid,
    output logic              tx_in_ready,
    input  logic              tx_in_cmd,
    input  logic [BYTE_W-1:0] tx_in_data,
    input  logic              tx_in_last,
    output logic              tx_out_valid,
    input  logic              tx_out_ready,
    output logic              tx_out_cmd,
    output logic [BYTE_W-1:0] tx_out_data
);
    item_t rx_in_item, rx_out_item, tx_in_item, tx_out_item;

    assign rx_in_item  = '{cmd: rx_in_cmd, data: rx_in_data};
    assign tx_in_item  = '{cmd: tx_in_cmd, data: tx_in_data};
    assign rx_out_cmd  = rx_out_item.cmd;
    assign rx_out_data = rx_out_item.data;
    assign tx_out_cmd  = tx_out_item.cmd;
    assign tx_out_data = tx_out_item.data;

    rle_expand u_expand (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (rx_in_valid),
        .in_ready  (rx_in_ready),
        .in_item   (rx_in_item),
        .out_valid (rx_out_valid),
        .out_ready (rx_out_ready),
        .out_item  (rx_out_item)
    );

    generate
        if (ENC_EN) begin : g_enc
            rle_compress u_compress (
                .clk       (clk),
                .rst_n     (rst_n),
                .in_valid  (tx_in_valid),
                .in_ready  (tx_in_ready),
                .in_item   (tx_in_item),
                .in_last   (tx_in_last),
                .out_valid (tx_out_valid),
                .out_ready (tx_out_ready),
                .out_item  (tx_out_item)
            );
        end else begin : g_bypass
            logic unused_last;
            assign unused_last  = tx_in_last;
            assign tx_out_valid = tx_in_valid;
            assign tx_in_ready  = tx_out_ready;
            assign tx_out_item  = tx_in_item;
        end
    endgenerate
endmodule

// File: tb/sim_rle_codec.sv
module sim_rle_codec;
    typedef struct {
        logic       cmd;
        logic [7:0] data;
        string      req;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_in_valid = 1'b0, rx_in_cmd = 1'b0;
    logic [7:0] rx_in_data = 8'h00;
    logic       rx_in_ready, rx_out_valid, rx_out_cmd;
    logic [7:0] rx_out_data;
    logic       rx_out_ready = 1'b0;
    logic       tx_in_valid = 1'b0, tx_in_cmd = 1'b0, tx_in_last = 1'b0;
    logic [7:0] tx_in_data = 8'h00;
    logic       tx_in_ready, tx_out_valid, tx_out_cmd;
    logic [7:0] tx_out_data;
    logic       tx_out_ready = 1'b0;

    int   n_run = 0;
    int   n_fail = 0;
    int   rx_mode = 0;
    int   tx_mode = 0;
    logic [15:0] lf = 16'hACE1;
    exp_t rxq[$];
    exp_t txq[$];

    logic       m_pend = 1'b0;
    logic [6:0] m_pcnt = 7'd0;
    logic [7:0] m_rbyte = 8'h00;
    int         m_rlen = 0;

    always #2 clk = ~clk;

    rle_codec u0 (
        .clk(clk), .rst_n(rst_n),
        .rx_in_valid(rx_in_valid), .rx_in_ready(rx_in_ready),
        .rx_in_cmd(rx_in_cmd), .rx_in_data(rx_in_data),
        .rx_out_valid(rx_out_valid), .rx_out_ready(rx_out_ready),
        .rx_out_cmd(rx_out_cmd), .rx_out_data(rx_out_data),
        .tx_in_valid(tx_in_valid), .tx_in_ready(tx_in_ready),
        .tx_in_cmd(tx_in_cmd), .tx_in_data(tx_in_data), .tx_in_last(tx_in_last),
        .tx_out_valid(tx_out_valid), .tx_out_ready(tx_out_ready),
        .tx_out_cmd(tx_out_cmd), .tx_out_data(tx_out_data)
    );

    task automatic chk(input logic ok, input string req, input int act, input int expv);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    always @(negedge clk) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        rx_out_ready = (rx_mode == 0) ? 1'b1 : (rx_mode == 1) ? (lf[0] | lf[5]) : 1'b0;
        tx_out_ready = (tx_mode == 0) ? 1'b1 : (tx_mode == 1) ? (lf[2] | lf[9]) : 1'b0;
    end

    // scoreboard monitors
    always @(negedge clk) begin
        #1;
        if (rst_n && rx_out_valid && rx_out_ready) begin
            if (rxq.size() == 0) begin
                chk(1'b0, "R1 rx extra item", {rx_out_cmd, rx_out_data}, 0);
            end else begin
                exp_t e;
                e = rxq.pop_front();
                chk({rx_out_cmd, rx_out_data} == {e.cmd, e.data}, e.req,
                    {rx_out_cmd, rx_out_data}, {e.cmd, e.data});
            end
        end
    end

    always @(negedge clk) begin
        #1;
        if (rst_n && tx_out_valid && tx_out_ready) begin
            if (txq.size() == 0) begin
                chk(1'b0, "R9 tx extra item", {tx_out_cmd, tx_out_data}, 0);
            end else begin
                exp_t e;
                e = txq.pop_front();
                chk({tx_out_cmd, tx_out_data} == {e.cmd, e.data}, e.req,
                    {tx_out_cmd, tx_out_data}, {e.cmd, e.data});
            end
        end
    end

    task automatic rx_push(input logic c, input logic [7:0] d, input string req);
        exp_t e;
        e.cmd = c; e.data = d; e.req = req;
        rxq.push_back(e);
    endtask

    task automatic tx_push(input logic c, input logic [7:0] d, input string req);
        exp_t e;
        e.cmd = c; e.data = d; e.req = req;
        txq.push_back(e);
    endtask

    // receive driver with model
    task automatic rx_put(input logic c, input logic [7:0] d, input string req);
        if (c && !d[7]) begin
            m_pend = 1'b1;
            m_pcnt = d[6:0];
        end else if (c) begin
            rx_push(1'b1, d, req);
            m_pend = 1'b0;
        end else begin
            int n;
            n = m_pend ? int'(m_pcnt) + 1 : 1;
            for (int i = 0; i < n; i++) rx_push(1'b0, d, req);
            m_pend = 1'b0;
        end
        @(negedge clk);
        rx_in_valid = 1'b1; rx_in_cmd = c; rx_in_data = d;
        forever begin
            #1;
            if (rx_in_ready) break;
            @(negedge clk);
        end
        @(posedge clk);
        @(negedge clk);
        rx_in_valid = 1'b0;
    endtask

    task automatic tx_flush(input string req);
        if (m_rlen >= 2) tx_push(1'b1, 8'(m_rlen - 1), req);
        if (m_rlen >= 1) tx_push(1'b0, m_rbyte, req);
        m_rlen = 0;
    endtask

    // transmit driver with model
    task automatic tx_put(input logic c, input logic [7:0] d, input logic last, input string req);
        if (c) begin
            tx_flush(req);
            tx_push(1'b1, d, req);
        end else begin
            if (m_rlen > 0 && d != m_rbyte) tx_flush(req);
            if (m_rlen == 0) m_rbyte = d;
            m_rlen++;
            if (m_rlen == 128 || last) tx_flush(req);
        end
        @(negedge clk);
        tx_in_valid = 1'b1; tx_in_cmd = c; tx_in_data = d; tx_in_last = last;
        forever begin
            #1;
            if (tx_in_ready) break;
            @(negedge clk);
        end
        @(posedge clk);
        @(negedge clk);
        tx_in_valid = 1'b0; tx_in_last = 1'b0;
    endtask

    task automatic drain();
        for (int i = 0; i < 3000 && (rxq.size() != 0 || txq.size() != 0); i++) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        #200000;
        chk(1'b0, "watchdog", 0, 1);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        #1;
        chk(rx_out_valid == 1'b0, "R10 rx valid in reset", rx_out_valid, 0);
        chk(tx_out_valid == 1'b0, "R10 tx valid in reset", tx_out_valid, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // receive path, random backpressure
        rx_mode = 1;
        rx_put(1'b0, 8'h3C, "R1");
        rx_put(1'b0, 8'hC3, "R1");
        rx_put(1'b1, 8'h00, "R2");
        rx_put(1'b0, 8'h5A, "R2 n=0");
        rx_put(1'b1, 8'h03, "R2");
        rx_put(1'b0, 8'h11, "R2 n=3");
        rx_put(1'b1, 8'h7F, "R2");
        rx_put(1'b0, 8'hEE, "R2 n=127");
        rx_put(1'b1, 8'h85, "R3");
        rx_put(1'b1, 8'h05, "R5");
        rx_put(1'b1, 8'h90, "R5 addr after count");
        rx_put(1'b0, 8'h21, "R5 single after dropped count");
        rx_put(1'b1, 8'h02, "R5");
        rx_put(1'b1, 8'h01, "R5");
        rx_put(1'b0, 8'h42, "R5 later count wins");
        drain();

        // R4: expansion under stalled sink
        rx_mode = 2;
        rx_put(1'b1, 8'h04, "R4");
        rx_put(1'b0, 8'hA5, "R4 copies");
        repeat (5) @(negedge clk);
        #1;
        chk(rx_in_ready == 1'b0, "R4 in_ready low during run", rx_in_ready, 0);
        chk(rx_out_valid == 1'b1, "R4 valid held", rx_out_valid, 1);
        chk(rx_out_data == 8'hA5, "R4 data held", rx_out_data, 8'hA5);
        rx_mode = 0;
        @(negedge clk); @(negedge clk);
        #1;
        chk(rx_in_ready == 1'b0, "R4 in_ready low mid run", rx_in_ready, 0);
        drain();

        // transmit path
        tx_mode = 1;
        tx_put(1'b0, 8'h11, 1'b1, "R7");
        for (int i = 0; i < 3; i++) tx_put(1'b0, 8'h22, i == 2, "R6");
        for (int i = 0; i < 130; i++) tx_put(1'b0, 8'h33, i == 129, "R8");
        tx_put(1'b0, 8'h44, 1'b0, "R9 mismatch");
        tx_put(1'b0, 8'h44, 1'b0, "R9 mismatch");
        tx_put(1'b0, 8'h55, 1'b1, "R9 mismatch");
        for (int i = 0; i < 3; i++) tx_put(1'b0, 8'h66, 1'b0, "R9 cmd flush");
        tx_put(1'b1, 8'h81, 1'b0, "R9 cmd flush");
        tx_put(1'b0, 8'h77, 1'b0, "R9 last");
        tx_put(1'b0, 8'h77, 1'b1, "R9 last");
        tx_put(1'b0, 8'h77, 1'b1, "R7 after last");
        tx_mode = 0;
        for (int i = 0; i < 128; i++) tx_put(1'b0, 8'h99, 1'b0, "R8 exact 128");
        tx_put(1'b0, 8'h99, 1'b1, "R8 exact 128");
        drain();

        chk(rxq.size() == 0, "R1 rx queue empty", rxq.size(), 0);
        chk(txq.size() == 0, "R6 tx queue empty", txq.size(), 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule